// File: doc/BRIEF.md
# Round Select Limit Output Stage

This block is the last stage of a wide filter datapath. It takes a 32-bit accumulated sample and reduces it to a 16-bit output word in three steps: round, limit, then window selection. Each cycle a 4-bit set index picks one of sixteen programmable parameter sets. Each set holds a 32-bit rounding constant, a 5-bit window position, and signed 32-bit upper and lower bounds. One global enable bit turns clamping on or off for all sets at once.

The set index is captured on the same clock edge as the data word. Every parameter of the chosen set travels down the pipeline with that sample. Switching sets from one cycle to the next therefore needs no dead cycles. A register write in the same cycle as a sample does not affect that sample.

Software programs the sets through a simple write strobe with a 7-bit address and 32-bit data. The result appears on the output three clocks after the sample enters.

Top module: `rslOutputStage`

## Requirements
- R1: While reset is asserted and for the first two clocks after its release, `resOut` is 0. After reset, every set has rounding 0, window position 0, upper bound 0x7FFFFFFF and lower bound 0x80000000, and limiting is off.
- R2: The set index value n, sampled on the same rising edge as `accIn`, selects parameter set n for that sample.
- R3: The rounding constant of the selected set is added to `accIn` modulo 2^32 before limiting and selection.
- R4: With limiting on, the rounded value is compared as two's complement. If it is greater than the upper bound, the result is the upper bound. Otherwise, if it is below the lower bound, the result is the lower bound. Otherwise it is unchanged.
- R5: With limiting off, the rounded value passes to selection unchanged, whatever the bounds are.
- R6: With window position s (0..16), `resOut` equals bits [s+15:s] of the limited value.
- R7: A window position from 17 to 31 behaves as position 16.
- R8: Writing the global register sets limiting to bit 0 of the write data. Bits 31:1 of that write are ignored.
- R9: `resOut` shows the result for a sample three rising edges after the edge that captured it. A register write on the capturing edge does not affect that sample. It does affect samples captured on later edges.
- R10: Write address map: `cfgAddr[6:4]` is the kind and `cfgAddr[3:0]` is the set. Kind 0 is rounding, kind 1 is window position (data bits 4:0), kind 2 is upper bound, kind 3 is lower bound, and kind 4 is the global register (set field ignored). Kinds 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| accIn | input | 32 | Accumulated sample |
| setIdx | input | 4 | Parameter set index for this sample |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 7 | Register write address (kind, set) |
| cfgWrData | input | 32 | Register write data |
| resOut | output | 16 | Registered 16-bit result |

## Verification
A wrong parameter-table entry or a stale pipeline copy of a set does not show until a sample uses that set. The error then appears on `resOut` exactly three clocks after the sample, so the reference model compares every cycle against a queue aligned to that latency. A clamp that is skipped or misordered shows only for values beyond a bound, and a bad window mux shows only for some window positions. The stimulus therefore sweeps all sixteen sets, all 32 window codes and values on both sides of each bound. It also mixes writes and samples in the same cycle, so a parameter taken one cycle too late shows as a one-sample mismatch.

// File: rtl/rslPkg.sv
package rslPkg;
  localparam int DATA_W  = 32;
  localparam int OUT_W   = 16;
  localparam int SHIFT_W = 5;
  localparam int IDX_W   = 4;

  // Parameters of one set, snapshot taken with the sample and carried down the pipe
  typedef struct packed {
    logic [DATA_W-1:0]  roundVal;
    logic [DATA_W-1:0]  upper;
    logic [DATA_W-1:0]  lower;
    logic [SHIFT_W-1:0] shift;
    logic               limitEn;
  } setCfg_t;

  // Write kinds carried in the upper address field
  typedef enum logic [2:0] {
    KIND_ROUND  = 3'd0,
    KIND_SHIFT  = 3'd1,
    KIND_UPPER  = 3'd2,
    KIND_LOWER  = 3'd3,
    KIND_GLOBAL = 3'd4
  } wrKind_e;
endpackage

// File: rtl/rslCtrl.sv
module rslCtrl
  import rslPkg::*;
#(
  parameter int NUM_SETS  = 16,
  parameter int MAX_SHIFT = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [IDX_W-1:0]         setIdx,
  input  logic                     cfgWrEn,
  input  logic [IDX_W+2:0]         cfgAddr,
  input  logic [DATA_W-1:0]        cfgWrData,
  output setCfg_t                  selCfg
);
  localparam logic [DATA_W-1:0]  UPPER_RST = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0]  LOWER_RST = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(MAX_SHIFT);

  logic [2:0]       wrKind;
  logic [IDX_W-1:0] wrSet;
  logic             globalWr;

  assign wrKind   = cfgAddr[IDX_W+2:IDX_W];
  assign wrSet    = cfgAddr[IDX_W-1:0];
  assign globalWr = cfgWrEn && (wrKind == KIND_GLOBAL);

  logic [DATA_W-1:0]  roundTbl [NUM_SETS];
  logic [DATA_W-1:0]  upperTbl [NUM_SETS];
  logic [DATA_W-1:0]  lowerTbl [NUM_SETS];
  logic [SHIFT_W-1:0] shiftTbl [NUM_SETS];
  logic               limitEn;

  for (genvar g = 0; g < NUM_SETS; g++) begin : gSet
    logic hit;
    assign hit = cfgWrEn && (wrSet == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        roundTbl[g] <= '0;
        upperTbl[g] <= UPPER_RST;
        lowerTbl[g] <= LOWER_RST;
        shiftTbl[g] <= '0;
      end else if (hit) begin
        case (wrKind)
          KIND_ROUND: roundTbl[g] <= cfgWrData;
          KIND_SHIFT: shiftTbl[g] <= cfgWrData[SHIFT_W-1:0];
          KIND_UPPER: upperTbl[g] <= cfgWrData;
          KIND_LOWER: lowerTbl[g] <= cfgWrData;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         limitEn <= 1'b0;
    else if (globalWr) limitEn <= cfgWrData[0];
  end

  logic [SHIFT_W-1:0] rawShift;
  always_comb begin
    rawShift        = shiftTbl[setIdx];
    selCfg.roundVal = roundTbl[setIdx];
    selCfg.upper    = upperTbl[setIdx];
    selCfg.lower    = lowerTbl[setIdx];
    selCfg.shift    = (rawShift > SHIFT_CAP) ? SHIFT_CAP : rawShift;
    selCfg.limitEn  = limitEn;
  end

  AST_SHIFT_CAPPED: assert property (@(posedge clk) disable iff (!rstN) selCfg.shift <= SHIFT_CAP); // R7
  AST_GLOBAL_HOLD: assert property (@(posedge clk) disable iff (!rstN) !globalWr |=> $stable(limitEn)); // R8
endmodule

// File: rtl/rslDatapath.sv
module rslDatapath
  import rslPkg::*;
#(
  parameter int MAX_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] accIn,
  input  setCfg_t           selCfg,
  output logic [OUT_W-1:0]  resOut
);
  localparam int NUM_WIN = MAX_SHIFT + 1;

  // Stage 1: round, and capture the chosen set with the sample
  logic [DATA_W-1:0] rndQ;
  setCfg_t           cfg1Q;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rndQ  <= '0;
      cfg1Q <= '0;
    end else begin
      rndQ  <= accIn + selCfg.roundVal;
      cfg1Q <= selCfg;
    end
  end

  // Stage 2: signed clamp, upper bound checked first
  logic [DATA_W-1:0]  limNext;
  logic [DATA_W-1:0]  limQ;
  logic [SHIFT_W-1:0] shift2Q;
  always_comb begin
    limNext = rndQ;
    if (cfg1Q.limitEn) begin
      if ($signed(rndQ) > $signed(cfg1Q.upper))      limNext = cfg1Q.upper;
      else if ($signed(rndQ) < $signed(cfg1Q.lower)) limNext = cfg1Q.lower;
    end
  end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limQ    <= '0;
      shift2Q <= '0;
    end else begin
      limQ    <= limNext;
      shift2Q <= cfg1Q.shift;
    end
  end

  // Stage 3: window selection
  logic [OUT_W-1:0] winArr [NUM_WIN];
  for (genvar s = 0; s < NUM_WIN; s++) begin : gWin
    assign winArr[s] = limQ[s+OUT_W-1:s];
  end
  always_ff @(posedge clk) begin
    if (!rstN) resOut <= '0;
    else       resOut <= winArr[shift2Q];
  end

  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfg1Q.limitEn && ($signed(cfg1Q.lower) <= $signed(cfg1Q.upper)))
    |=> (($signed(limQ) <= $signed($past(cfg1Q.upper))) && ($signed(limQ) >= $signed($past(cfg1Q.lower))))); // R4
  AST_NO_LIMIT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !cfg1Q.limitEn |=> (limQ == $past(rndQ))); // R5
  AST_SHIFT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (shift2Q == $past(cfg1Q.shift))); // R9
endmodule

// File: rtl/rslOutputStage.sv
module rslOutputStage
  import rslPkg::*;
#(
  parameter int NUM_SETS  = 16,
  parameter int MAX_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       accIn,
  input  logic [3:0]        setIdx,
  input  logic              cfgWrEn,
  input  logic [6:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [15:0]       resOut
);
  setCfg_t selCfg;

  rslCtrl #(.NUM_SETS(NUM_SETS), .MAX_SHIFT(MAX_SHIFT)) uCtrl (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .selCfg(selCfg)
  );

  rslDatapath #(.MAX_SHIFT(MAX_SHIFT)) uPath (
    .clk(clk), .rstN(rstN), .accIn(accIn), .selCfg(selCfg), .resOut(resOut)
  );
endmodule

// File: tb/tb_rslOutputStage.sv
`timescale 1ns/1ps
module tb_rslOutputStage;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] accIn = '0;
  logic [3:0]  setIdx = '0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [15:0] resOut;

  always #2 clk = ~clk;

  rslOutputStage dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic [31:0] mRound [16];
  logic [31:0] mUpper [16];
  logic [31:0] mLower [16];
  int          mShift [16];
  bit          mLim;

  logic [15:0] expQ [$];
  string       tagQ [$];

  function automatic logic [15:0] refOut(logic [31:0] d, int idx);
    longint v;
    longint hi;
    longint lo;
    int sh;
    logic [31:0] r;
    r  = d + mRound[idx];
    v  = longint'($signed(r));
    hi = longint'($signed(mUpper[idx]));
    lo = longint'($signed(mLower[idx]));
    if (mLim) begin
      if (v > hi) v = hi;
      else if (v < lo) v = lo;
    end
    sh = (mShift[idx] > 16) ? 16 : mShift[idx];
    r  = 32'(v);
    return 16'(r >> sh);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: resOut=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive sample (and optional write), then check the output due now
  task automatic step(logic [31:0] d, int idx, string tag,
                      bit wr = 0, int kind = 0, int set = 0, logic [31:0] wd = '0);
    accIn     = d;
    setIdx    = 4'(idx);
    cfgWrEn   = wr;
    cfgAddr   = {3'(kind), 4'(set)};
    cfgWrData = wd;
    expQ.push_back(refOut(d, idx));
    tagQ.push_back(tag);
    if (wr) begin
      case (kind)
        0: mRound[set] = wd;
        1: mShift[set] = int'(wd[4:0]);
        2: mUpper[set] = wd;
        3: mLower[set] = wd;
        4: mLim = wd[0];
        default: ;
      endcase
    end
    @(negedge clk);
    check(tagQ.pop_front(), resOut, expQ.pop_front());
  endtask

  task automatic wr(int kind, int set, logic [31:0] wd, string tag);
    step(32'h0, 0, tag, 1, kind, set, wd);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mRound[i] = '0; mUpper[i] = 32'h7FFF_FFFF; mLower[i] = 32'h8000_0000; mShift[i] = 0;
    end
    mLim = 0;
    repeat (4) @(negedge clk);
    check("R1 reset", resOut, 16'h0);
    rstN = 1'b1;
    expQ.push_back(16'h0); tagQ.push_back("R1 post-reset");
    expQ.push_back(16'h0); tagQ.push_back("R1 post-reset");

    // R1 defaults: plain low half passes
    step(32'h1234_5678, 3, "R1 defaults");
    step(32'hFFFF_ABCD, 9, "R1 defaults");

    // R2: distinct per-set rounding and shifts, sweep the index
    for (int n = 0; n < 16; n++) wr(0, n, 32'(n) * 32'h0001_0101, "R2 setup");
    for (int n = 0; n < 16; n++) wr(1, n, 32'(n), "R2 setup");
    for (int n = 0; n < 16; n++) step(32'h0F0F_3C3C, n, "R2 set select");
    for (int n = 15; n >= 0; n--) step(32'hA5A5_5A5A, n, "R2 set select");

    // R3: rounding with wrap
    wr(0, 2, 32'h0000_8000, "R3 setup");
    wr(1, 2, 32'd16, "R3 setup");
    step(32'h0001_7FFF, 2, "R3 round down");
    step(32'h0001_8000, 2, "R3 round up");
    step(32'hFFFF_8000, 2, "R3 wrap");
    wr(0, 4, 32'hFFFF_FFFF, "R3 setup");
    step(32'h0000_0000, 4, "R3 negative round");

    // R4: limiting on
    wr(0, 5, 32'h0, "R4 setup");
    wr(1, 5, 32'd8, "R4 setup");
    wr(2, 5, 32'h0000_7F00, "R4 setup");
    wr(3, 5, 32'hFFFF_8000, "R4 setup");
    wr(4, 0, 32'h1, "R4 enable");
    step(32'h0000_7F00, 5, "R4 at upper");
    step(32'h0000_7F01, 5, "R4 above upper");
    step(32'h7FFF_FFFF, 5, "R4 max positive");
    step(32'hFFFF_8000, 5, "R4 at lower");
    step(32'hFFFF_7FFF, 5, "R4 below lower");
    step(32'h8000_0000, 5, "R4 min negative");
    wr(2, 6, 32'h0000_0010, "R4 setup");
    wr(3, 6, 32'h0000_0100, "R4 setup");
    step(32'h0000_0050, 6, "R4 inverted bounds upper first");
    step(32'h0000_0005, 6, "R4 inverted bounds");

    // R5: limiting off, same values pass
    wr(4, 7, 32'h0, "R5 disable");
    step(32'h0000_7F01, 5, "R5 no clamp");
    step(32'h8000_0000, 5, "R5 no clamp");
    step(32'h0000_0050, 6, "R5 no clamp");

    // R6 / R7: every window code
    for (int s = 0; s < 32; s++) begin
      wr(1, 8, 32'(s), s <= 16 ? "R6 setup" : "R7 setup");
      step(32'hC3A5_96E1, 8, s <= 16 ? "R6 window" : "R7 window saturate");
      step(32'h1357_9BDF, 8, s <= 16 ? "R6 window" : "R7 window saturate");
    end
    wr(1, 8, 32'hFFFF_FFF1, "R10 shift uses low bits");
    step(32'h1357_9BDF, 8, "R10 shift uses low bits");

    // R8: only bit 0 of the global write counts
    wr(4, 3, 32'hFFFF_FFFE, "R8 setup");
    step(32'h0000_7F01, 5, "R8 reserved bits ignored");
    wr(4, 0, 32'h0000_0001, "R8 setup");
    step(32'h0000_7F01, 5, "R8 bit0 enables");
    wr(4, 0, 32'h8000_0000, "R8 setup");
    step(32'h0000_7F01, 5, "R8 bit0 clear disables");

    // R10: kinds 5..7 change nothing
    wr(5, 5, 32'h1111_1111, "R10 setup");
    wr(6, 5, 32'h2222_2222, "R10 setup");
    wr(7, 5, 32'h3333_3333, "R10 setup");
    step(32'h0000_7F01, 5, "R10 unused kinds ignored");
    step(32'h0000_1234, 5, "R10 unused kinds ignored");

    // R9: writes in the same cycle as samples, back-to-back
    step(32'h0000_4444, 9, "R9 same-cycle write", 1, 0, 9, 32'h0000_1000);
    step(32'h0000_4444, 9, "R9 next sample sees write");
    step(32'h0001_0000, 9, "R9 same-cycle write", 1, 1, 9, 32'd4);
    step(32'h0001_0000, 9, "R9 next sample sees write");
    for (int i = 0; i < 600; i++) begin
      bit w;
      w = ($urandom % 3) == 0;
      step($urandom, int'($urandom % 16), "R9 mixed traffic", w,
           int'($urandom % 8), int'($urandom % 16), $urandom);
    end
    for (int i = 0; i < 3; i++) step(32'h0, 0, "R9 drain");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: resOut=%h expected=finish", resOut);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule